// File: doc/BRIEF.md
# Cache-Block Invalidate Request Unit

This unit sits between the decode stage and the data cache. It accepts one decoded cache-block invalidate operation at a time. Each operation carries the base-register value, the immediate field, the current privilege level and two environment-configuration control fields. The unit then settles on exactly one outcome:

- an illegal-instruction exception;
- an invalidate request to the cache;
- a flush request issued in place of the invalidate.

Requests carry the base value with its low log2(`BLOCK_BYTES`) bits cleared. The unaligned value is kept so that a cache access fault is reported at the address the program supplied.

The controller is a state machine with six states:

- `ST_IDLE`: waits for an operation.
- `ST_ISSUE`: presents the cache request.
- `ST_WAIT`: waits for the cache response.
- `ST_DONE`: reports normal completion.
- `ST_FAULT`: reports an access fault.
- `ST_ILLEGAL`: reports an illegal instruction.

The transitions are:

- `ST_IDLE` goes to `ST_ILLEGAL` when the accepted operation is refused, and to `ST_ISSUE` otherwise.
- `ST_ISSUE` goes to `ST_WAIT` when the cache takes the request.
- `ST_WAIT` goes to `ST_FAULT` on a fault response and to `ST_DONE` on a clean one.
- `ST_DONE`, `ST_FAULT` and `ST_ILLEGAL` each return to `ST_IDLE` after one cycle.

Top module: `cbinv_req_unit`

## Requirements
- R1: After reset, `op_ready` is 1 and `cache_req_valid`, `done_valid` and `exc_valid` are 0.
- R2: `cache_req_addr` equals `op_base` with its low log2(`BLOCK_BYTES`) bits forced to zero. An unaligned base never raises an exception by itself.
- R3: A non-zero `op_imm` causes an illegal-instruction exception (`exc_cause`=0, `exc_tval`=0) and no cache request.
- R4: At privilege 2'b11 (machine), the unit always issues an invalidate (`cache_req_flush`=0), whatever the control fields hold.
- R5: At privilege 2'b01 (supervisor), only `cfg_mctl` is consulted. The encoding is: 00 traps, 01 flushes, 10 is reserved and traps, 11 invalidates.
- R6: At privilege 2'b00 (user), both `cfg_mctl` and `cfg_sctl` are decoded with the R5 encoding, and the more restrictive result is taken. Trap beats flush, and flush beats invalidate.
- R7: The reserved privilege code 2'b10 raises an illegal-instruction exception.
- R8: While `cache_req_valid` is 1 and `cache_req_ready` is 0, the request address and opcode stay unchanged on the next cycle.
- R9: A fault response raises `exc_valid` with `exc_cause`=1 and `exc_tval` equal to the raw base value, and the unit issues no further request for that operation.
- R10: A clean response produces one `done_valid` cycle with `exc_valid`=0, after which `op_ready` returns to 1.
- R11: An operation accepted at a clock edge shows its request (or its illegal report) in the following cycle. `op_ready` stays 0 until the outcome cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit idle and accepting an operation |
| op_base | input | XLEN | Base-register value, any alignment |
| op_imm | input | 12 | Immediate field of the encoding |
| op_priv | input | 2 | Current privilege level |
| cfg_mctl | input | 2 | Machine-level control field |
| cfg_sctl | input | 2 | Supervisor-level control field |
| cache_req_valid | output | 1 | Cache request present |
| cache_req_ready | input | 1 | Cache takes the request |
| cache_req_addr | output | XLEN | Block-aligned address |
| cache_req_flush | output | 1 | 1 = flush, 0 = invalidate |
| cache_rsp_valid | input | 1 | Cache response present |
| cache_rsp_fault | input | 1 | Response reports an access fault |
| done_valid | output | 1 | Operation finished this cycle |
| exc_valid | output | 1 | Finished with an exception |
| exc_cause | output | 1 | 0 = illegal instruction, 1 = access fault |
| exc_tval | output | XLEN | Faulting address (raw base) or zero |

## Verification
Random operations mix all four privilege codes, every pair of control-field values, occasional non-zero immediates, random unaligned bases, random cache stalls and random fault responses. This separates the trap, flush and invalidate decisions and exposes any bias in how the user-level combination picks the more restrictive result. Directed cases cover two things:

- Machine mode under trapping fields, which tells the always-invalidate rule apart from the field decode.
- The reserved field code against the flush code, which tells reserved-as-trap apart from reserved-as-pass.

Fault responses on bases with non-zero low bits tell raw-address reporting apart from aligned-address reporting. Long ready stalls show whether the request is held steady.

// File: rtl/cbinv_pkg.sv
package cbinv_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    // outcome ordered by restrictiveness: larger value wins
    typedef enum logic [1:0] {
        ACT_INVAL = 2'd0,
        ACT_FLUSH = 2'd1,
        ACT_TRAP  = 2'd2
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT,
        ST_ILLEGAL
    } state_e;

    localparam logic EXC_ILLEGAL = 1'b0;
    localparam logic EXC_ACCESS  = 1'b1;

    function automatic act_e ctl_decode(input logic [1:0] fld);
        act_e a;
        unique case (fld)
            2'b00:   a = ACT_TRAP;
            2'b01:   a = ACT_FLUSH;
            2'b10:   a = ACT_TRAP;
            default: a = ACT_INVAL;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cbinv_perm.sv
module cbinv_perm
    import cbinv_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [1:0]       priv,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       mctl,
    input  logic [1:0]       sctl,
    output act_e             act
);

    act_e m_act;
    act_e s_act;
    act_e user_act;

    always_comb begin
        m_act    = ctl_decode(mctl);
        s_act    = ctl_decode(sctl);
        user_act = (m_act > s_act) ? m_act : s_act;
    end

    always_comb begin
        if (imm != '0) begin
            act = ACT_TRAP;
        end else begin
            unique case (priv)
                PRIV_M:  act = ACT_INVAL;
                PRIV_S:  act = m_act;
                PRIV_U:  act = user_act;
                default: act = ACT_TRAP;
            endcase
        end
    end

endmodule

// File: rtl/cbinv_align.sv
module cbinv_align #(
    parameter int XLEN        = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic [XLEN-1:0] base,
    output logic [XLEN-1:0] aligned
);

    localparam int OFF_BITS = $clog2(BLOCK_BYTES);

    generate
        if (OFF_BITS == 0) begin : g_pass
            assign aligned = base;
        end else begin : g_mask
            assign aligned = {base[XLEN-1:OFF_BITS], {OFF_BITS{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/cbinv_ctrl.sv
module cbinv_ctrl
    import cbinv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    output logic            op_ready,
    input  act_e            act,
    input  logic [XLEN-1:0] base_raw,
    input  logic [XLEN-1:0] base_aligned,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [XLEN-1:0] req_addr,
    output logic            req_flush,
    input  logic            rsp_valid,
    input  logic            rsp_fault,
    output logic            done_valid,
    output logic            exc_valid,
    output logic            exc_cause,
    output logic [XLEN-1:0] exc_tval
);

    state_e          state_q;
    state_e          state_d;
    logic [XLEN-1:0] raw_q;
    logic [XLEN-1:0] addr_q;
    logic            flush_q;
    logic            accept;

    assign accept = op_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= '0;
            addr_q  <= '0;
            flush_q <= 1'b0;
        end else if (accept) begin
            raw_q   <= base_raw;
            addr_q  <= base_aligned;
            flush_q <= (act == ACT_FLUSH);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    state_d = (act == ACT_TRAP) ? ST_ILLEGAL : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (req_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    state_d = rsp_fault ? ST_FAULT : ST_DONE;
                end
            end
            ST_DONE:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            ST_ILLEGAL: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_ready   = 1'b0;
        req_valid  = 1'b0;
        done_valid = 1'b0;
        exc_valid  = 1'b0;
        exc_cause  = EXC_ILLEGAL;
        exc_tval   = '0;
        req_addr   = addr_q;
        req_flush  = flush_q;
        unique case (state_q)
            ST_IDLE:  op_ready  = 1'b1;
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  done_valid = 1'b1;
            ST_FAULT: begin
                done_valid = 1'b1;
                exc_valid  = 1'b1;
                exc_cause  = EXC_ACCESS;
                exc_tval   = raw_q;
            end
            ST_ILLEGAL: begin
                done_valid = 1'b1;
                exc_valid  = 1'b1;
                exc_cause  = EXC_ILLEGAL;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cbinv_req_unit.sv
module cbinv_req_unit
    import cbinv_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int IMM_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [XLEN-1:0]  op_base,
    input  logic [IMM_W-1:0] op_imm,
    input  logic [1:0]       op_priv,
    input  logic [1:0]       cfg_mctl,
    input  logic [1:0]       cfg_sctl,
    output logic             cache_req_valid,
    input  logic             cache_req_ready,
    output logic [XLEN-1:0]  cache_req_addr,
    output logic             cache_req_flush,
    input  logic             cache_rsp_valid,
    input  logic             cache_rsp_fault,
    output logic             done_valid,
    output logic             exc_valid,
    output logic             exc_cause,
    output logic [XLEN-1:0]  exc_tval
);

    act_e            act;
    logic [XLEN-1:0] aligned;

    cbinv_perm #(.IMM_W(IMM_W)) u_perm (
        .priv (op_priv),
        .imm  (op_imm),
        .mctl (cfg_mctl),
        .sctl (cfg_sctl),
        .act  (act)
    );

    cbinv_align #(.XLEN(XLEN), .BLOCK_BYTES(BLOCK_BYTES)) u_align (
        .base    (op_base),
        .aligned (aligned)
    );

    cbinv_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_ready     (op_ready),
        .act          (act),
        .base_raw     (op_base),
        .base_aligned (aligned),
        .req_valid    (cache_req_valid),
        .req_ready    (cache_req_ready),
        .req_addr     (cache_req_addr),
        .req_flush    (cache_req_flush),
        .rsp_valid    (cache_rsp_valid),
        .rsp_fault    (cache_rsp_fault),
        .done_valid   (done_valid),
        .exc_valid    (exc_valid),
        .exc_cause    (exc_cause),
        .exc_tval     (exc_tval)
    );

endmodule

// File: rtl/cbinv_req_unit_chk.sv
module cbinv_req_unit_chk #(
    parameter int XLEN        = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int IMM_W       = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_ready,
    input logic [IMM_W-1:0] op_imm,
    input logic [1:0]       op_priv,
    input logic             cache_req_valid,
    input logic             cache_req_ready,
    input logic [XLEN-1:0]  cache_req_addr,
    input logic             cache_req_flush,
    input logic             cache_rsp_valid,
    input logic             cache_rsp_fault,
    input logic             done_valid,
    input logic             exc_valid,
    input logic             exc_cause,
    input logic [XLEN-1:0]  exc_tval
);

    localparam logic [XLEN-1:0] LOW_MASK = XLEN'(BLOCK_BYTES - 1);

    // R2: request address has no offset bits
    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid |-> ((cache_req_addr & LOW_MASK) == '0));

    // R3: non-zero immediate gives an illegal report and no request
    p_imm_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_imm != '0) |=>
            (exc_valid && exc_cause == 1'b0 && !cache_req_valid));

    // R4: machine mode always invalidates
    p_machine_inval_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_imm == '0 && op_priv == 2'b11) |=>
            (cache_req_valid && !cache_req_flush));

    // R8: request held while stalled
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req_valid && !cache_req_ready) |=>
            (cache_req_valid && $stable(cache_req_addr) && $stable(cache_req_flush)));

    // R9: fault response yields access exception, no retry
    p_fault_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_rsp_valid && cache_rsp_fault && !op_ready && !cache_req_valid && !done_valid) |=>
            (exc_valid && exc_cause == 1'b1 && !cache_req_valid));

    // R9: nothing is issued in the cycle after completion
    p_no_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!cache_req_valid && op_ready));

    // R11: request, completion and readiness never overlap
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_req_valid, done_valid, op_ready}));

    // R10: an exception only comes with a completion
    p_exc_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> done_valid);

    // R3: illegal report carries a zero address
    p_illegal_tval_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == 1'b0) |-> (exc_tval == '0));

endmodule

bind cbinv_req_unit cbinv_req_unit_chk #(
    .XLEN(XLEN), .BLOCK_BYTES(BLOCK_BYTES), .IMM_W(IMM_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_valid        (op_valid),
    .op_ready        (op_ready),
    .op_imm          (op_imm),
    .op_priv         (op_priv),
    .cache_req_valid (cache_req_valid),
    .cache_req_ready (cache_req_ready),
    .cache_req_addr  (cache_req_addr),
    .cache_req_flush (cache_req_flush),
    .cache_rsp_valid (cache_rsp_valid),
    .cache_rsp_fault (cache_rsp_fault),
    .done_valid      (done_valid),
    .exc_valid       (exc_valid),
    .exc_cause       (exc_cause),
    .exc_tval        (exc_tval)
);

// File: tb/cbinv_req_unit_tb.sv
module cbinv_req_unit_tb;

    localparam int XLEN        = 32;
    localparam int BLOCK_BYTES = 64;
    localparam int IMM_W       = 12;
    localparam logic [XLEN-1:0] LOW_MASK = XLEN'(BLOCK_BYTES - 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic             op_ready;
    logic [XLEN-1:0]  op_base = '0;
    logic [IMM_W-1:0] op_imm = '0;
    logic [1:0]       op_priv = 2'b11;
    logic [1:0]       cfg_mctl = 2'b11;
    logic [1:0]       cfg_sctl = 2'b11;
    logic             cache_req_valid;
    logic             cache_req_ready = 1'b0;
    logic [XLEN-1:0]  cache_req_addr;
    logic             cache_req_flush;
    logic             cache_rsp_valid = 1'b0;
    logic             cache_rsp_fault = 1'b0;
    logic             done_valid;
    logic             exc_valid;
    logic             exc_cause;
    logic [XLEN-1:0]  exc_tval;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cbinv_req_unit #(.XLEN(XLEN), .BLOCK_BYTES(BLOCK_BYTES), .IMM_W(IMM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_base(op_base), .op_imm(op_imm), .op_priv(op_priv),
        .cfg_mctl(cfg_mctl), .cfg_sctl(cfg_sctl),
        .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
        .cache_req_addr(cache_req_addr), .cache_req_flush(cache_req_flush),
        .cache_rsp_valid(cache_rsp_valid), .cache_rsp_fault(cache_rsp_fault),
        .done_valid(done_valid), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_tval(exc_tval)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 invalidate, 1 flush, 2 trap
    function automatic int fld_act(input logic [1:0] f);
        case (f)
            2'b01:   return 1;
            2'b11:   return 0;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_act(input logic [IMM_W-1:0] imm, input logic [1:0] pv,
                                   input logic [1:0] m, input logic [1:0] s);
        int a;
        int b;
        if (imm != '0) return 2;
        a = fld_act(m);
        b = fld_act(s);
        case (pv)
            2'b11:   return 0;
            2'b01:   return a;
            2'b00:   return (a > b) ? a : b;
            default: return 2;
        endcase
    endfunction

    task automatic run_op(input logic [XLEN-1:0] base, input logic [IMM_W-1:0] imm,
                          input logic [1:0] pv, input logic [1:0] m, input logic [1:0] s,
                          input int stall, input bit fault, input string tag);
        int ea;
        ea = exp_act(imm, pv, m, s);
        @(negedge clk);
        chk({tag, " R10 ready before op"}, XLEN'(op_ready), 1);
        op_valid = 1'b1; op_base = base; op_imm = imm; op_priv = pv;
        cfg_mctl = m; cfg_sctl = s;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        op_base = ~base;
        chk({tag, " R11 ready low after accept"}, XLEN'(op_ready), 0);
        if (ea == 2) begin
            if (imm != '0) chk({tag, " R3 illegal exc"}, {exc_valid, exc_cause}, 2'b10);
            else if (pv == 2'b10) chk({tag, " R7 illegal exc"}, {exc_valid, exc_cause}, 2'b10);
            else if (pv == 2'b00) chk({tag, " R6 user trap"}, {exc_valid, exc_cause}, 2'b10);
            else chk({tag, " R5 super trap"}, {exc_valid, exc_cause}, 2'b10);
            chk({tag, " R3 no request, tval zero"}, {cache_req_valid, exc_tval}, '0);
            chk({tag, " R11 done with illegal"}, XLEN'(done_valid), 1);
        end else begin
            chk({tag, " R11 request valid"}, XLEN'(cache_req_valid), 1);
            chk({tag, " R2 aligned addr"}, cache_req_addr, base & ~LOW_MASK);
            if (pv == 2'b11) chk({tag, " R4 machine inval"}, XLEN'(cache_req_flush), 0);
            else if (pv == 2'b01) chk({tag, " R5 super opcode"}, XLEN'(cache_req_flush), XLEN'(ea));
            else chk({tag, " R6 user opcode"}, XLEN'(cache_req_flush), XLEN'(ea));
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                chk({tag, " R8 held addr"}, {cache_req_valid, cache_req_addr}, {1'b1, base & ~LOW_MASK});
                chk({tag, " R8 held opcode"}, XLEN'(cache_req_flush), XLEN'(ea));
            end
            cache_req_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            cache_req_ready = 1'b0;
            chk({tag, " R9 request dropped after accept"}, XLEN'(cache_req_valid), 0);
            cache_rsp_valid = 1'b1; cache_rsp_fault = fault;
            @(posedge clk);
            @(negedge clk);
            cache_rsp_valid = 1'b0; cache_rsp_fault = 1'b0;
            chk({tag, " R10 done"}, XLEN'(done_valid), 1);
            if (fault) begin
                chk({tag, " R9 access exc"}, {exc_valid, exc_cause}, 2'b11);
                chk({tag, " R9 raw tval"}, exc_tval, base);
            end else begin
                chk({tag, " R10 no exc"}, XLEN'(exc_valid), 0);
            end
            @(negedge clk);
            chk({tag, " R9 no retry"}, XLEN'(cache_req_valid), 0);
            chk({tag, " R10 ready again"}, XLEN'(op_ready), 1);
            return;
        end
        @(negedge clk);
        chk({tag, " R10 ready again"}, XLEN'(op_ready), 1);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", XLEN'(op_ready), 1);
        chk("R1 reset outputs", {cache_req_valid, done_valid, exc_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", XLEN'(op_ready), 1);

        run_op(32'h1000_003F, '0, 2'b11, 2'b00, 2'b00, 0, 1'b0, "m-trapfields");
        run_op(32'h2000_0001, '0, 2'b01, 2'b10, 2'b11, 0, 1'b0, "s-rsv");
        run_op(32'h2000_0041, '0, 2'b01, 2'b01, 2'b00, 2, 1'b0, "s-flush");
        run_op(32'h3000_0080, '0, 2'b00, 2'b11, 2'b01, 0, 1'b0, "u-flush");
        run_op(32'h3000_00C5, '0, 2'b00, 2'b01, 2'b10, 0, 1'b0, "u-trap");
        run_op(32'h4000_0007, 12'h004, 2'b11, 2'b11, 2'b11, 0, 1'b0, "imm");
        run_op(32'h5000_0000, '0, 2'b10, 2'b11, 2'b11, 0, 1'b0, "rsvpriv");
        run_op(32'hDEAD_BEEF, '0, 2'b00, 2'b11, 2'b11, 5, 1'b1, "fault-unaligned");

        for (int n = 0; n < 300; n++) begin
            logic [IMM_W-1:0] im;
            im = (($urandom % 8) == 0) ? IMM_W'($urandom) : '0;
            run_op($urandom, im, 2'($urandom), 2'($urandom), 2'($urandom),
                   int'($urandom % 4), (($urandom % 5) == 0), "rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule